// File: doc/BRIEF.md
# Radix-2 SRT Fraction Divider with Carry-Save Remainder

This block divides a non-negative fraction by a normalized fraction one quotient digit per clock. The partial remainder lives in two vectors, a sum and a carry, so an iteration costs one row of full adders and never waits on a carry chain. A short adder over the top bits of both vectors estimates the doubled remainder. From that estimate the block picks a digit of minus one, zero or plus one, and adds the divisor, nothing, or the negated divisor into the carry-save pair.

Positive and negative digits are collected in two separate bit vectors. After the last digit, one finishing cycle adds the two remainder vectors together and subtracts the negative digit vector from the positive one. If the remainder came out negative, the divisor is added back and the quotient is lowered by one.

A caller presents the operands with a one-cycle start pulse while the unit is idle. It then waits for the one-cycle done pulse, after which the results stay on the outputs until the next accepted start.

Top module: `srt2_divider`

## Requirements
- R1: While reset is asserted and after its release, busy, done, quotient and remainder are all zero until the first accepted start.
- R2: A start pulse seen on a rising edge while busy is low captures dividend and divisor, and busy is high in the following cycle.
- R3: done is high for exactly one cycle, beginning W+1 rising edges after the edge that captured start, and busy is low whenever done is high.
- R4: For a divisor with its most significant bit set and a dividend below the divisor, both read as unsigned W-bit integers, the outputs satisfy dividend·2^W = quotient·divisor + remainder with 0 ≤ remainder < divisor.
- R5: A zero dividend gives a zero quotient and a zero remainder.
- R6: While idle and without a start, quotient and remainder keep their values.
- R7: A start pulse while busy is high is ignored: the operation in flight finishes with its own operands, and no additional done pulse follows.
- R8: While a division runs, the value held in the carry-save pair stays within [−divisor, divisor), including at the extreme operands (smallest and largest divisor, dividend just below the divisor).
- R9: A start in the same cycle as done is accepted, so divisions may follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present operands |
| dividend | input | W | Unsigned fraction, must be below divisor |
| divisor | input | W | Unsigned fraction, most significant bit set |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse when results update |
| quotient | output | W | Quotient fraction bits |
| remainder | output | W | Remainder scaled by 2^W, in [0, divisor) |

## Verification
The bench builds the divider with W = 8. This keeps every divisor in [128, 255] close enough that the smallest divisor, the largest divisor, and dividends one below the divisor are all hit directly, alongside a few hundred random pairs. At that width the carry-save remainder often ends negative, so the final correction path is exercised many times. The same narrow width makes the estimate's guard-bit margin matter on nearly every run. The default of 16 is only elaborated.

// File: rtl/srt2_divider.sv
module srt2_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  localparam int L  = W + 3;
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [L-1:0]  ps, pc;
  logic [W-1:0]  dv, pbits, nbits;

  logic [L-1:0] ss, sc, dx, addend, nsum, maj, ncar, full, fixed;
  logic [4:0]   est;
  logic         nz, ng, cin;
  logic [W-1:0] qraw;

  assign ss  = {ps[L-2:0], 1'b0};
  assign sc  = {pc[L-2:0], 1'b0};
  assign est = ss[L-1:L-5] + sc[L-1:L-5];
  assign nz  = ~(&est[4:1]);
  assign ng  = est[4] & ~(&est[3:1]);
  assign dx  = {3'b000, dv};

  assign addend = !nz ? '0 : (ng ? dx : ~dx);
  assign cin    = nz & ~ng;
  assign nsum   = ss ^ sc ^ addend;
  assign maj    = (ss & sc) | (ss & addend) | (sc & addend);
  assign ncar   = {maj[L-2:0], cin};

  assign full  = ps + pc;
  assign fixed = full[L-1] ? full + dx : full;
  assign qraw  = pbits - nbits;
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      ps        <= '0;
      pc        <= '0;
      dv        <= '0;
      pbits     <= '0;
      nbits     <= '0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ps    <= {3'b000, dividend};
          pc    <= '0;
          dv    <= divisor;
          pbits <= '0;
          nbits <= '0;
          cnt   <= '0;
          st    <= S_RUN;
        end
        S_RUN: begin
          ps    <= nsum;
          pc    <= ncar;
          pbits <= {pbits[W-2:0], nz & ~ng};
          nbits <= {nbits[W-2:0], nz & ng};
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= S_FIN;
        end
        S_FIN: begin
          remainder <= fixed[W-1:0];
          quotient  <= full[L-1] ? qraw - 1'b1 : qraw;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remainder < dv));

  a_r8_pr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> ($signed(full) < $signed(dx) && $signed(full) >= -$signed(dx)));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(dv));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: tb/srt2_divider_bench.sv
module srt2_divider_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done;
  logic [W-1:0] quotient, remainder;

  srt2_divider #(.W(W)) u_srt2_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  always #4 clk = ~clk;

  typedef struct { int q; int r; int c; } item_t;
  item_t exp_q[$];
  int cyc = 0;
  int runs = 0;
  int fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic go(input int z, input int d);
    item_t it;
    while (busy) @(negedge clk);
    dividend = W'(z);
    divisor  = W'(d);
    start    = 1'b1;
    it.q = (z << W) / d;
    it.r = (z << W) % d;
    it.c = cyc + W + 2;
    exp_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor: R3 latency, R4/R5 results, R7 no spurious done
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected done", 1, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(int'(quotient) == it.q, "R4", "quotient", quotient, it.q);
        chk(int'(remainder) == it.r, "R4", "remainder", remainder, it.r);
        chk(cyc == it.c, "R3", "done cycle", cyc, it.c);
        chk(busy == 1'b0, "R3", "busy with done", busy, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] hq, hr;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(quotient == 0 && remainder == 0, "R1", "outputs in reset", quotient, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && done == 0 && quotient == 0, "R1", "after release", quotient, 0);

    // R5 zero dividend
    go(0, 8'h80);
    go(0, 8'hFF);
    // R8 extreme operands
    go(8'h7F, 8'h80);
    go(8'hFE, 8'hFF);
    go(1, 8'hFF);
    go(1, 8'h80);
    go(8'h80, 8'h81);
    go(8'h7F, 8'hFF);
    drain();

    // R7 start while busy
    go(8'h55, 8'hC3);
    repeat (2) @(negedge clk);
    dividend = 8'h11; divisor = 8'h9A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (W + 4) @(negedge clk);

    // R6 outputs hold while idle
    hq = quotient; hr = remainder;
    repeat (6) @(negedge clk);
    chk(quotient == hq, "R6", "quotient hold", quotient, hq);
    chk(remainder == hr, "R6", "remainder hold", remainder, hr);

    // R4 random, issued back to back (R9)
    for (int i = 0; i < 300; i++) begin
      int d, z;
      d = 128 + ($urandom % 128);
      z = $urandom % d;
      go(z, d);
    end
    drain();
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule